// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the hardwired controller of a multi-cycle processor datapath. It holds a small state register and, from the current state alone, drives every control point the datapath needs in that cycle: the program-counter write enables and source, the memory read, write and address select, the instruction-register load, the register-file write, destination and data selects, the two ALU operand selects and the ALU operation class. The only input besides clock and reset is the 6-bit opcode field of the instruction register. That field is read once, when the sequencer leaves the decode state.

Every instruction starts with the same two states. Fetch reads memory at PC, loads the instruction register and writes PC+4 back into PC. Decode lets the datapath latch both source operands and form a branch target speculatively, before the opcode is known. Each instruction class then follows its own short path and returns to fetch. R-type takes 4 cycles, loads take 5, stores take 4, and branches and jumps take 3. An unrecognised opcode goes from decode straight back to fetch and writes nothing on the way.

Top module: `mcyc_ctrl`

## Requirements
- R1: rst_n is active low and synchronous. A clock edge with rst_n low puts the sequencer in fetch, whatever state it was in. Fetch outputs appear for as long as reset is held and in the first cycle after it is released.
- R2: In fetch the outputs are pc_wr=1, mem_rd=1, ir_wr=1, addr_sel=0 (PC addresses memory), alu_a_sel=0 (PC), alu_b_sel=01 (constant 4), alu_op=00 (add) and pc_src=00 (ALU result). All other outputs are 0. Fetch is always followed by decode.
- R3: In decode the outputs are alu_a_sel=0, alu_b_sel=11 (sign-extended immediate shifted left by 2) and alu_op=00. All write enables are 0. These values do not depend on the opcode.
- R4: Opcode 000000 (R-type) runs fetch, decode, execute and write-back, which is 4 cycles. Execute drives alu_a_sel=1 (register A), alu_b_sel=00 (register B) and alu_op=10 (function-field decoded). Write-back drives rf_wr=1, rf_dst_sel=1 (rd) and rf_src_sel=0 (ALU output register).
- R5: Opcode 100011 (load) runs 5 cycles. The address state drives alu_a_sel=1, alu_b_sel=10 (sign-extended immediate) and alu_op=00. The read state drives mem_rd=1 and addr_sel=1 (ALU output register). Write-back drives rf_wr=1, rf_dst_sel=0 (rt) and rf_src_sel=1 (memory data register).
- R6: Opcode 101011 (store) runs 4 cycles. It has the same address state as a load, then a state with mem_wr=1 and addr_sel=1.
- R7: Opcode 000100 (branch if equal) runs 3 cycles. Its single execute state drives alu_a_sel=1, alu_b_sel=00, alu_op=01 (subtract), pc_wr_cond=1 and pc_src=01 (ALU output register).
- R8: Opcode 000010 (jump) runs 3 cycles. Its single execute state drives pc_wr=1 and pc_src=10 (jump target).
- R9: Any other opcode returns from decode to fetch, for 2 cycles in total, and asserts no write enable after fetch.
- R10: The opcode is sampled only at the edge that leaves decode. Changing it later in the instruction changes neither the path nor the outputs.
- R11: In no cycle are two of ir_wr, rf_wr and mem_wr high together. mem_rd and mem_wr are never both high, and neither are pc_wr and pc_wr_cond.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write gated by the datapath's zero flag |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU output register |
| ir_wr | output | 1 | Instruction register load |
| rf_wr | output | 1 | Register file write |
| rf_dst_sel | output | 1 | Destination register: 0 rt, 1 rd |
| rf_src_sel | output | 1 | Write data: 0 ALU output register, 1 memory data register |
| alu_a_sel | output | 1 | First ALU operand: 0 PC, 1 register A |
| alu_b_sel | output | 2 | Second ALU operand: 00 B, 01 four, 10 immediate, 11 immediate shifted by 2 |
| alu_op | output | 2 | ALU class: 00 add, 01 subtract, 10 function-decoded |
| pc_src | output | 2 | PC source: 00 ALU result, 01 ALU output register, 10 jump target |

## Verification
The outputs are a pure decode of the state register, so a wrong state shows at the ports in the same cycle it is entered. A wrong transition is therefore visible one cycle after the edge that caused it, as a control vector that does not match the expected step of the instruction. A wrong instruction length shows one cycle later, as an early or missing instruction-register load. The bench sweeps all 64 opcode values and compares the whole control vector against the expected per-class sequence at every step. It also changes the opcode after decode and asserts reset in the middle of an instruction.

// File: rtl/mcyc_pkg.sv
// Package mcyc_pkg
// Shared state encoding, control-field encodings and the control bundle
// used by the multi-cycle sequencer. Assumes a 4-bit state register.
package mcyc_pkg;

    typedef enum logic [3:0] {
        ST_FETCH    = 4'd0,
        ST_DECODE   = 4'd1,
        ST_LW_ADDR  = 4'd2,
        ST_LW_READ  = 4'd3,
        ST_LW_WB    = 4'd4,
        ST_SW_ADDR  = 4'd5,
        ST_SW_WRITE = 4'd6,
        ST_R_EXEC   = 4'd7,
        ST_R_WB     = 4'd8,
        ST_BR_EXEC  = 4'd9,
        ST_J_EXEC   = 4'd10
    } state_e;

    typedef enum logic [1:0] {
        ALUB_REG   = 2'b00,
        ALUB_FOUR  = 2'b01,
        ALUB_IMM   = 2'b10,
        ALUB_IMMX4 = 2'b11
    } alu_b_e;

    typedef enum logic [1:0] {
        ALUOP_ADD  = 2'b00,
        ALUOP_SUB  = 2'b01,
        ALUOP_FUNC = 2'b10,
        ALUOP_RSV  = 2'b11
    } alu_op_e;

    typedef enum logic [1:0] {
        PCS_ALU    = 2'b00,
        PCS_ALUREG = 2'b01,
        PCS_JUMP   = 2'b10,
        PCS_RSV    = 2'b11
    } pc_src_e;

    typedef struct packed {
        logic    pc_wr;
        logic    pc_wr_cond;
        logic    mem_rd;
        logic    mem_wr;
        logic    addr_sel;
        logic    ir_wr;
        logic    rf_wr;
        logic    rf_dst_sel;
        logic    rf_src_sel;
        logic    alu_a_sel;
        alu_b_e  alu_b;
        alu_op_e alu_op;
        pc_src_e pc_src;
    } ctrl_t;

endpackage

// File: rtl/mcyc_next_state.sv
// Module mcyc_next_state
// Combinational next-state function. The opcode is consulted only in the
// decode state, which picks a class-specific path. Every other state has a
// fixed successor. Assumes the opcode values are distinct.
module mcyc_next_state
    import mcyc_pkg::*;
#(
    parameter int              OPC_W    = 6,
    parameter logic [OPC_W-1:0] OP_RTYPE = 6'b000000,
    parameter logic [OPC_W-1:0] OP_LOAD  = 6'b100011,
    parameter logic [OPC_W-1:0] OP_STORE = 6'b101011,
    parameter logic [OPC_W-1:0] OP_BEQ   = 6'b000100,
    parameter logic [OPC_W-1:0] OP_JUMP  = 6'b000010
) (
    input  state_e           cur,
    input  logic [OPC_W-1:0] opcode,
    output state_e           nxt
);

    state_e dispatch;

    // Choose the first class-specific state from the opcode
    always_comb begin
        if (opcode == OP_RTYPE)      dispatch = ST_R_EXEC;
        else if (opcode == OP_LOAD)  dispatch = ST_LW_ADDR;
        else if (opcode == OP_STORE) dispatch = ST_SW_ADDR;
        else if (opcode == OP_BEQ)   dispatch = ST_BR_EXEC;
        else if (opcode == OP_JUMP)  dispatch = ST_J_EXEC;
        else                         dispatch = ST_FETCH;
    end

    // Fixed successor for each state; decode uses the dispatch result
    always_comb begin
        case (cur)
            ST_FETCH:    nxt = ST_DECODE;
            ST_DECODE:   nxt = dispatch;
            ST_LW_ADDR:  nxt = ST_LW_READ;
            ST_LW_READ:  nxt = ST_LW_WB;
            ST_SW_ADDR:  nxt = ST_SW_WRITE;
            ST_R_EXEC:   nxt = ST_R_WB;
            default:     nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mcyc_state_reg.sv
// Module mcyc_state_reg
// State register with synchronous active-low reset to fetch. The
// assertions on the path order sit here next to the register.
module mcyc_state_reg
    import mcyc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  state_e nxt,
    output state_e cur_q
);

    // Load the next state, or fetch when reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= ST_FETCH;
        else        cur_q <= nxt;
    end

    // R2: fetch is always followed by decode
    a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == ST_FETCH) |=> (cur_q == ST_DECODE));

    // R4: R-type execute is followed by its write-back
    a_r4_exec_then_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == ST_R_EXEC) |=> (cur_q == ST_R_WB));

    // R5: load address, read and write-back stay in order
    a_r5_load_read_then_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == ST_LW_READ) |=> (cur_q == ST_LW_WB));

    // R10: a load path cannot turn into a store path, whatever the opcode
    a_r10_load_path_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == ST_LW_ADDR) |=> (cur_q == ST_LW_READ));

    // R6: store address leads to the memory write
    a_r6_store_addr_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == ST_SW_ADDR) |=> (cur_q == ST_SW_WRITE));

    // R7: branch finishes in one execute state
    a_r7_branch_single_state: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == ST_BR_EXEC) |=> (cur_q == ST_FETCH));

    // R8: jump finishes in one execute state
    a_r8_jump_single_state: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == ST_J_EXEC) |=> (cur_q == ST_FETCH));

endmodule

// File: rtl/mcyc_out_decode.sv
// Module mcyc_out_decode
// Moore output decoder: maps the current state to the full control
// bundle. Unused state codes drive all controls low.
module mcyc_out_decode
    import mcyc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  state_e cur,
    output ctrl_t  ctrl
);

    // Control points for each state, defaults low
    always_comb begin
        ctrl = '0;
        case (cur)
            ST_FETCH: begin
                ctrl.mem_rd    = 1'b1;
                ctrl.addr_sel  = 1'b0;
                ctrl.ir_wr     = 1'b1;
                ctrl.alu_a_sel = 1'b0;
                ctrl.alu_b     = ALUB_FOUR;
                ctrl.alu_op    = ALUOP_ADD;
                ctrl.pc_src    = PCS_ALU;
                ctrl.pc_wr     = 1'b1;
            end
            ST_DECODE: begin
                ctrl.alu_a_sel = 1'b0;
                ctrl.alu_b     = ALUB_IMMX4;
                ctrl.alu_op    = ALUOP_ADD;
            end
            ST_LW_ADDR, ST_SW_ADDR: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b     = ALUB_IMM;
                ctrl.alu_op    = ALUOP_ADD;
            end
            ST_LW_READ: begin
                ctrl.mem_rd   = 1'b1;
                ctrl.addr_sel = 1'b1;
            end
            ST_LW_WB: begin
                ctrl.rf_wr      = 1'b1;
                ctrl.rf_dst_sel = 1'b0;
                ctrl.rf_src_sel = 1'b1;
            end
            ST_SW_WRITE: begin
                ctrl.mem_wr   = 1'b1;
                ctrl.addr_sel = 1'b1;
            end
            ST_R_EXEC: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b     = ALUB_REG;
                ctrl.alu_op    = ALUOP_FUNC;
            end
            ST_R_WB: begin
                ctrl.rf_wr      = 1'b1;
                ctrl.rf_dst_sel = 1'b1;
                ctrl.rf_src_sel = 1'b0;
            end
            ST_BR_EXEC: begin
                ctrl.alu_a_sel  = 1'b1;
                ctrl.alu_b      = ALUB_REG;
                ctrl.alu_op     = ALUOP_SUB;
                ctrl.pc_wr_cond = 1'b1;
                ctrl.pc_src     = PCS_ALUREG;
            end
            ST_J_EXEC: begin
                ctrl.pc_wr  = 1'b1;
                ctrl.pc_src = PCS_JUMP;
            end
            default: ctrl = '0;
        endcase
    end

    // R11: at most one of the three storage writes per cycle
    a_r11_write_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl.ir_wr, ctrl.rf_wr, ctrl.mem_wr}));

    // R11: memory is never read and written in the same cycle
    a_r11_mem_rw_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl.mem_rd && ctrl.mem_wr));

    // R11: the two PC write enables are never both active
    a_r11_pc_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl.pc_wr && ctrl.pc_wr_cond));

endmodule

// File: rtl/mcyc_ctrl.sv
// Module mcyc_ctrl
// Top of the multi-cycle control sequencer: next-state logic, state
// register and Moore output decoder. Assumes the opcode input holds the
// instruction register's opcode field during decode.
module mcyc_ctrl
    import mcyc_pkg::*;
#(
    parameter int               OPC_W    = 6,
    parameter logic [OPC_W-1:0] OP_RTYPE = 6'b000000,
    parameter logic [OPC_W-1:0] OP_LOAD  = 6'b100011,
    parameter logic [OPC_W-1:0] OP_STORE = 6'b101011,
    parameter logic [OPC_W-1:0] OP_BEQ   = 6'b000100,
    parameter logic [OPC_W-1:0] OP_JUMP  = 6'b000010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    output logic             pc_wr,
    output logic             pc_wr_cond,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             addr_sel,
    output logic             ir_wr,
    output logic             rf_wr,
    output logic             rf_dst_sel,
    output logic             rf_src_sel,
    output logic             alu_a_sel,
    output logic [1:0]       alu_b_sel,
    output logic [1:0]       alu_op,
    output logic [1:0]       pc_src
);

    state_e cur_q;
    state_e nxt;
    ctrl_t  ctrl;

    mcyc_next_state #(
        .OPC_W    (OPC_W),
        .OP_RTYPE (OP_RTYPE),
        .OP_LOAD  (OP_LOAD),
        .OP_STORE (OP_STORE),
        .OP_BEQ   (OP_BEQ),
        .OP_JUMP  (OP_JUMP)
    ) u_next (
        .cur    (cur_q),
        .opcode (opcode),
        .nxt    (nxt)
    );

    mcyc_state_reg u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (nxt),
        .cur_q (cur_q)
    );

    mcyc_out_decode u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .cur   (cur_q),
        .ctrl  (ctrl)
    );

    // Unpack the control bundle onto the ports
    assign pc_wr      = ctrl.pc_wr;
    assign pc_wr_cond = ctrl.pc_wr_cond;
    assign mem_rd     = ctrl.mem_rd;
    assign mem_wr     = ctrl.mem_wr;
    assign addr_sel   = ctrl.addr_sel;
    assign ir_wr      = ctrl.ir_wr;
    assign rf_wr      = ctrl.rf_wr;
    assign rf_dst_sel = ctrl.rf_dst_sel;
    assign rf_src_sel = ctrl.rf_src_sel;
    assign alu_a_sel  = ctrl.alu_a_sel;
    assign alu_b_sel  = ctrl.alu_b;
    assign alu_op     = ctrl.alu_op;
    assign pc_src     = ctrl.pc_src;

    // R9: an unrecognised opcode leaves decode straight for fetch
    a_r9_unknown_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == ST_DECODE && opcode != OP_RTYPE && opcode != OP_LOAD &&
         opcode != OP_STORE && opcode != OP_BEQ && opcode != OP_JUMP)
        |=> ir_wr);

endmodule

// File: tb/mcyc_ctrl_bench.sv
// Bench for mcyc_ctrl: exhaustive opcode sweep with per-step comparison
// of the whole control vector, opcode changes after decode, and reset
// asserted in the middle of an instruction.
module mcyc_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'd0;
    logic pc_wr, pc_wr_cond, mem_rd, mem_wr, addr_sel, ir_wr;
    logic rf_wr, rf_dst_sel, rf_src_sel, alu_a_sel;
    logic [1:0] alu_b_sel, alu_op, pc_src;

    int checks = 0;
    int errors = 0;

    localparam logic [5:0] OPR = 6'b000000;
    localparam logic [5:0] OPL = 6'b100011;
    localparam logic [5:0] OPS = 6'b101011;
    localparam logic [5:0] OPB = 6'b000100;
    localparam logic [5:0] OPJ = 6'b000010;

    mcyc_ctrl u_mcyc_ctrl (
        .clk(clk), .rst_n(rst_n), .opcode(opcode),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_wr(ir_wr),
        .rf_wr(rf_wr), .rf_dst_sel(rf_dst_sel), .rf_src_sel(rf_src_sel),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
        .pc_src(pc_src)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] vec_now();
        return {pc_wr, pc_wr_cond, mem_rd, mem_wr, addr_sel, ir_wr, rf_wr,
                rf_dst_sel, rf_src_sel, alu_a_sel, alu_b_sel, alu_op, pc_src};
    endfunction

    function automatic logic [15:0] mk(logic pcw, logic pcc, logic mrd, logic mwr,
                                       logic asl, logic irw, logic rfw, logic dst,
                                       logic src, logic asel, logic [1:0] b,
                                       logic [1:0] op, logic [1:0] ps);
        return {pcw, pcc, mrd, mwr, asl, irw, rfw, dst, src, asel, b, op, ps};
    endfunction

    // Class: 0 R-type, 1 load, 2 store, 3 branch, 4 jump, 5 unrecognised
    function automatic int class_of(logic [5:0] op);
        if (op == OPR) return 0;
        if (op == OPL) return 1;
        if (op == OPS) return 2;
        if (op == OPB) return 3;
        if (op == OPJ) return 4;
        return 5;
    endfunction

    function automatic int len_of(int cls);
        case (cls)
            0: return 4;
            1: return 5;
            2: return 4;
            3: return 3;
            4: return 3;
            default: return 2;
        endcase
    endfunction

    // Expected control vector for step n of an instruction of class cls
    function automatic logic [15:0] exp_ctrl(int cls, int n);
        logic [15:0] fetch_v, dec_v, addr_v;
        fetch_v = mk(1,0,1,0,0,1,0,0,0,0,2'b01,2'b00,2'b00);
        dec_v   = mk(0,0,0,0,0,0,0,0,0,0,2'b11,2'b00,2'b00);
        addr_v  = mk(0,0,0,0,0,0,0,0,0,1,2'b10,2'b00,2'b00);
        if (n == 0) return fetch_v;
        if (n == 1) return dec_v;
        case (cls)
            0: return (n == 2) ? mk(0,0,0,0,0,0,0,0,0,1,2'b00,2'b10,2'b00)
                               : mk(0,0,0,0,0,0,1,1,0,0,2'b00,2'b00,2'b00);
            1: return (n == 2) ? addr_v
                    : (n == 3) ? mk(0,0,1,0,1,0,0,0,0,0,2'b00,2'b00,2'b00)
                               : mk(0,0,0,0,0,0,1,0,1,0,2'b00,2'b00,2'b00);
            2: return (n == 2) ? addr_v
                               : mk(0,0,0,1,1,0,0,0,0,0,2'b00,2'b00,2'b00);
            3: return mk(0,1,0,0,0,0,0,0,0,1,2'b00,2'b01,2'b01);
            4: return mk(1,0,0,0,0,0,0,0,0,0,2'b00,2'b00,2'b10);
            default: return fetch_v;
        endcase
    endfunction

    function automatic string tag_of(int cls, int n);
        if (n == 0) return "R2";
        if (n == 1) return "R3";
        case (cls)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            3: return "R7";
            4: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(bit ok, string tag, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Run one instruction from fetch; optionally alter the opcode after decode (R10)
    task automatic run_instr(logic [5:0] op, logic [5:0] alt, bit scramble);
        int cls;
        int n;
        cls = class_of(op);
        n = 0;
        opcode = op;
        do begin
            chk(vec_now() == exp_ctrl(cls, n),
                scramble ? "R10" : tag_of(cls, n), vec_now(), exp_ctrl(cls, n));
            @(posedge clk);
            @(negedge clk);
            n++;
            if (scramble && n == 2) opcode = alt;
        end while (!ir_wr && n < 8);
        chk(n == len_of(cls), scramble ? "R10" : tag_of(cls, 2),
            16'(n), 16'(len_of(cls)));
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(vec_now() == exp_ctrl(0, 0), "R1", vec_now(), exp_ctrl(0, 0));
        rst_n = 1'b1;

        // Sweep of every opcode value (R2..R9)
        for (int k = 0; k < 64; k++) begin
            run_instr(6'(k), 6'd0, 1'b0);
        end

        // R10: change the opcode after decode to another class
        run_instr(OPR, OPL, 1'b1);
        run_instr(OPL, OPS, 1'b1);
        run_instr(OPS, OPL, 1'b1);
        run_instr(OPB, OPJ, 1'b1);
        run_instr(OPJ, OPB, 1'b1);
        run_instr(6'b111111, OPL, 1'b1);

        // R1: reset asserted in the load read state
        opcode = OPL;
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
        end
        chk(vec_now() == exp_ctrl(1, 3), "R5", vec_now(), exp_ctrl(1, 3));
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(vec_now() == exp_ctrl(0, 0), "R1", vec_now(), exp_ctrl(0, 0));
        @(posedge clk);
        @(negedge clk);
        chk(vec_now() == exp_ctrl(0, 0), "R1", vec_now(), exp_ctrl(0, 0));
        rst_n = 1'b1;
        run_instr(OPS, 6'd0, 1'b0);

        // R1: reset asserted during R-type write-back
        opcode = OPR;
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
        end
        chk(vec_now() == exp_ctrl(0, 3), "R4", vec_now(), exp_ctrl(0, 3));
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(vec_now() == exp_ctrl(0, 0), "R1", vec_now(), exp_ctrl(0, 0));
        run_instr(OPB, 6'd0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule